// File: doc/BRIEF.md
# Dirty Row Span Coalescer

This block walks a frame one row at a time. For each row it asks whether the row has changed, and it turns the answers into a short list of update rectangles. Rows that changed and sit next to each other are merged into one rectangle that spans the full frame width. A run that is still open at the bottom of the frame is closed there. When the caller says that the display mode has changed, the block skips the walk and issues one rectangle that covers the whole frame.

The caller sends a one-cycle start request that carries the frame height, the frame width and a mode-changed flag. For a normal scan the block first raises a one-cycle snapshot strobe, which tells the dirty tracker to freeze its state for the frame and clear it. After that the block puts each row index on `row_idx` with `row_req` high and samples `row_dirty` in that same cycle. Records leave on a valid/ready port. The scan waits while a record is pending, and `done` pulses once the last record has been taken.

Top module: `dirty_span_coalescer`

## Requirements
- R1: During and right after reset, `busy`, `snap_clear`, `row_req`, `upd_valid` and `done` are all low.
- R2: A start with `start_mode_chg` high produces exactly one record with x=0, y=0, w=`start_width`, h=`start_height`. It raises no snapshot strobe and requests no rows.
- R3: A start with `start_mode_chg` low requests rows 0, 1, …, height−1 exactly once each, in increasing order. Each request lasts one cycle with `row_req` high, and `row_dirty` is sampled in that same cycle.
- R4: A scan raises `snap_clear` for exactly one cycle, before its first row request.
- R5: If a clean row arrives while a run is open, one record is emitted with x=0, y=start row of the run, w=frame width and h=current row − start row, and the run closes. A run opens at the first dirty row seen while no run is open.
- R6: If a run is still open after row height−1, it is emitted with h = height − start row.
- R7: A frame with no dirty rows emits no record. The records of one frame come out in increasing y order and never overlap.
- R8: While `upd_valid` is high and `upd_ready` is low, the record fields hold steady, and no row is requested while a record is pending.
- R9: `done` pulses for one cycle after the last record of the frame has been accepted, or after the scan when there is no record. `busy` drops in the cycle after that pulse.
- R10: A start request that arrives while `busy` is high has no effect. It produces no record and changes no latched dimension.
- R11: A scan with height 0 requests no rows and emits no record, but it still raises the snapshot strobe and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | One-cycle start request, taken only when idle |
| start_height | input | ROW_W | Frame height in rows |
| start_width | input | COL_W | Frame width in pixels |
| start_mode_chg | input | 1 | Mode changed: issue one full-frame record |
| busy | output | 1 | A frame is in progress |
| snap_clear | output | 1 | One-cycle strobe to snapshot and clear the dirty state |
| row_req | output | 1 | A row is being examined this cycle |
| row_idx | output | ROW_W | Index of the row being examined |
| row_dirty | input | 1 | Dirty bit for `row_idx`, sampled when `row_req` is high |
| upd_valid | output | 1 | An update record is offered |
| upd_ready | input | 1 | The consumer takes the record |
| upd_x | output | COL_W | Record x (always 0) |
| upd_y | output | ROW_W | Record first row |
| upd_w | output | COL_W | Record width |
| upd_h | output | ROW_W | Record row count |
| done | output | 1 | One-cycle pulse when the frame is finished |

## Verification
The bench tries every dirty pattern for heights 1 to 6, which covers a run at row 0, a run that ends on the last row, runs of a single row and a frame that is fully dirty. A design that drops the flush at the end of the frame loses the trailing rectangle. A design with an off-by-one run height reports rectangles that overlap or leave gaps. Random backpressure on `upd_ready` exposes a scan that keeps moving or changes record fields while a record is blocked. A start request injected in mid-scan catches a design that restarts or emits a stray full-frame record. The mode-change and zero-height frames catch a design that scans when it should not, or one that never raises `done`.

// File: rtl/dsc_pkg.sv
// Shared definitions for the dirty row span coalescer.
// Assumes: nothing beyond the encodings below.
package dsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start request
        ST_SNAP = 3'd1,   // snapshot strobe cycle
        ST_SCAN = 3'd2,   // walking rows
        ST_TAIL = 3'd3,   // flush a run left open at frame end
        ST_FIN  = 3'd4    // wait for last record to drain, then done
    } dsc_state_e;
endpackage

// File: rtl/dsc_ctrl.sv
// Frame sequencer: accepts start requests, raises the snapshot strobe,
// walks the row index, and ends the frame with a done pulse.
// Assumes: slot_full reports a pending output record; the scan stalls on it.
module dsc_ctrl
    import dsc_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [ROW_W-1:0] start_height,
    input  logic [COL_W-1:0] start_width,
    input  logic             start_mode_chg,
    input  logic             slot_full,
    input  logic             run_open,
    output logic             busy,
    output logic             snap_clear,
    output logic             row_req,
    output logic [ROW_W-1:0] row_idx,
    output logic             mc_go,
    output logic             tail_go,
    output logic [ROW_W-1:0] height_q,
    output logic [COL_W-1:0] width_q,
    output logic             done
);
    dsc_state_e state;

    // Decoded strobes derived from the current state.
    always_comb begin
        busy       = (state != ST_IDLE);
        snap_clear = (state == ST_SNAP);
        row_req    = (state == ST_SCAN) && !slot_full;
        mc_go      = (state == ST_IDLE) && start_valid && start_mode_chg;
        tail_go    = (state == ST_TAIL) && run_open && !slot_full;
        done       = (state == ST_FIN) && !slot_full;
    end

    // State, latched dimensions and row counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            height_q <= '0;
            width_q  <= '0;
            row_idx  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start_valid) begin
                    height_q <= start_height;
                    width_q  <= start_width;
                    state    <= start_mode_chg ? ST_FIN : ST_SNAP;
                end
                ST_SNAP: begin
                    row_idx <= '0;
                    state   <= (height_q == '0) ? ST_TAIL : ST_SCAN;
                end
                ST_SCAN: if (row_req) begin
                    if (row_idx == height_q - 1'b1) state <= ST_TAIL;
                    else                            row_idx <= row_idx + 1'b1;
                end
                ST_TAIL: if (!run_open || !slot_full) state <= ST_FIN;
                ST_FIN:  if (!slot_full) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_valid) |=> ($stable(height_q) && $stable(width_q)));
endmodule

// File: rtl/dsc_run.sv
// Run tracker: opens a run on the first dirty row, closes it on a clean
// row or at frame end, and forms the record to emit.
// Assumes: row_dirty is meaningful only while row_req is high.
module dsc_run #(
    parameter int ROW_W = 8,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_clear,
    input  logic             row_req,
    input  logic [ROW_W-1:0] row_idx,
    input  logic             row_dirty,
    input  logic             tail_go,
    input  logic             mc_go,
    input  logic [ROW_W-1:0] height_q,
    input  logic [COL_W-1:0] width_q,
    input  logic [ROW_W-1:0] start_height,
    input  logic [COL_W-1:0] start_width,
    output logic             run_open,
    output logic             emit,
    output logic [ROW_W-1:0] emit_y,
    output logic [ROW_W-1:0] emit_h,
    output logic [COL_W-1:0] emit_w
);
    logic [ROW_W-1:0] run_start;
    logic             close_clean;

    // Record formation for the three emit sources.
    always_comb begin
        close_clean = row_req && !row_dirty && run_open;
        emit        = close_clean || tail_go || mc_go;
        emit_y      = mc_go ? '0 : run_start;
        emit_w      = mc_go ? start_width : width_q;
        if (mc_go)        emit_h = start_height;
        else if (tail_go) emit_h = height_q - run_start;
        else              emit_h = row_idx - run_start;
    end

    // Open/close the current run of dirty rows.
    always_ff @(posedge clk) begin
        if (!rst_n || snap_clear) begin
            run_open  <= 1'b0;
            run_start <= '0;
        end else if (row_req && row_dirty && !run_open) begin
            run_open  <= 1'b1;
            run_start <= row_idx;
        end else if (close_clean || tail_go) begin
            run_open  <= 1'b0;
        end
    end

    // R5
    run_opens_on_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_open) |-> $past(row_req && row_dirty));
    // R5
    scan_emit_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit && !mc_go) |-> (emit_h != '0));
endmodule

// File: rtl/dsc_outq.sv
// Single-entry output register for update records with valid/ready.
// Assumes: load is raised only while the slot is empty.
module dsc_outq #(
    parameter int ROW_W = 8,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] in_y,
    input  logic [ROW_W-1:0] in_h,
    input  logic [COL_W-1:0] in_w,
    input  logic             ready,
    output logic             valid,
    output logic [ROW_W-1:0] out_y,
    output logic [ROW_W-1:0] out_h,
    output logic [COL_W-1:0] out_w
);
    // Hold a record until the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            out_y <= '0;
            out_h <= '0;
            out_w <= '0;
        end else if (load) begin
            valid <= 1'b1;
            out_y <= in_y;
            out_h <= in_h;
            out_w <= in_w;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(out_y) && $stable(out_h) && $stable(out_w)));
endmodule

// File: rtl/dirty_span_coalescer.sv
// Top: scans a frame's per-row dirty bits and emits full-width update
// rectangles, or one full-frame rectangle after a mode change.
// Assumes: row_dirty answers row_idx combinationally in the request cycle.
module dirty_span_coalescer #(
    parameter int ROW_W = 8,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_valid,
    input  logic [ROW_W-1:0] start_height,
    input  logic [COL_W-1:0] start_width,
    input  logic             start_mode_chg,
    output logic             busy,
    output logic             snap_clear,
    output logic             row_req,
    output logic [ROW_W-1:0] row_idx,
    input  logic             row_dirty,
    output logic             upd_valid,
    input  logic             upd_ready,
    output logic [COL_W-1:0] upd_x,
    output logic [ROW_W-1:0] upd_y,
    output logic [COL_W-1:0] upd_w,
    output logic [ROW_W-1:0] upd_h,
    output logic             done
);
    logic             run_open, mc_go, tail_go, emit;
    logic [ROW_W-1:0] height_q, emit_y, emit_h;
    logic [COL_W-1:0] width_q, emit_w;

    assign upd_x = '0;

    dsc_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_height(start_height),
        .start_width(start_width), .start_mode_chg(start_mode_chg),
        .slot_full(upd_valid), .run_open(run_open),
        .busy(busy), .snap_clear(snap_clear), .row_req(row_req),
        .row_idx(row_idx), .mc_go(mc_go), .tail_go(tail_go),
        .height_q(height_q), .width_q(width_q), .done(done)
    );

    dsc_run #(.ROW_W(ROW_W), .COL_W(COL_W)) u_run (
        .clk(clk), .rst_n(rst_n), .snap_clear(snap_clear),
        .row_req(row_req), .row_idx(row_idx), .row_dirty(row_dirty),
        .tail_go(tail_go), .mc_go(mc_go),
        .height_q(height_q), .width_q(width_q),
        .start_height(start_height), .start_width(start_width),
        .run_open(run_open), .emit(emit),
        .emit_y(emit_y), .emit_h(emit_h), .emit_w(emit_w)
    );

    dsc_outq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_outq (
        .clk(clk), .rst_n(rst_n), .load(emit),
        .in_y(emit_y), .in_h(emit_h), .in_w(emit_w),
        .ready(upd_ready), .valid(upd_valid),
        .out_y(upd_y), .out_h(upd_h), .out_w(upd_w)
    );

    // R6 R7
    rect_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ({1'b0, upd_y} + {1'b0, upd_h} <= {1'b0, height_q}));
    // R8
    no_scan_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_ready) |=> !row_req);
endmodule

// File: tb/tb_dirty_span_coalescer.sv
module tb_dirty_span_coalescer;
    localparam int ROW_W = 8;
    localparam int COL_W = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_valid = 1'b0, start_mode_chg = 1'b0, upd_ready = 1'b0;
    logic [ROW_W-1:0] start_height = '0;
    logic [COL_W-1:0] start_width = '0;
    logic busy, snap_clear, row_req, row_dirty, upd_valid, done;
    logic [ROW_W-1:0] row_idx, upd_y, upd_h;
    logic [COL_W-1:0] upd_x, upd_w;
    logic [15:0] pat = '0;
    logic [7:0]  lfsr = 8'hA7;

    int errors = 0, checks = 0, cycles = 0;
    int exp_n, got_n;
    int exp_y [16];
    int exp_h [16];
    int got_y [16];
    int got_h [16];
    int got_w [16];
    int got_x [16];

    assign row_dirty = pat[row_idx[3:0]];

    always #4 clk = ~clk;

    dirty_span_coalescer #(.ROW_W(ROW_W), .COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
        .start_height(start_height), .start_width(start_width),
        .start_mode_chg(start_mode_chg), .busy(busy), .snap_clear(snap_clear),
        .row_req(row_req), .row_idx(row_idx), .row_dirty(row_dirty),
        .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_x(upd_x),
        .upd_y(upd_y), .upd_w(upd_w), .upd_h(upd_h), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Arithmetic reference: runs of set bits become (start, length) records.
    task automatic build_expect(input int h);
        int ys;
        ys = -1; exp_n = 0;
        for (int r = 0; r < h; r++) begin
            if (pat[r] && ys < 0) ys = r;
            if (!pat[r] && ys >= 0) begin
                exp_y[exp_n] = ys; exp_h[exp_n] = r - ys; exp_n++; ys = -1;
            end
        end
        if (ys >= 0) begin exp_y[exp_n] = ys; exp_h[exp_n] = h - ys; exp_n++; end
    endtask

    task automatic run_frame(input int h, input int w, input bit mc, input bit interfere);
        int next_row, snaps, iter;
        bit snap_late, req_pend, hold_prev, done_seen;
        int hy, hh, hw;
        if (mc) begin
            exp_n = 1; exp_y[0] = 0; exp_h[0] = h;
        end else build_expect(h);
        got_n = 0; next_row = 0; snaps = 0; snap_late = 0; req_pend = 0;
        hold_prev = 0; done_seen = 0; hy = 0; hh = 0; hw = 0;
        @(negedge clk);
        start_valid = 1'b1; start_height = ROW_W'(h); start_width = COL_W'(w);
        start_mode_chg = mc;
        @(negedge clk);
        start_valid = 1'b0;
        for (iter = 0; iter < 400; iter++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            upd_ready = lfsr[0] | lfsr[2];
            if (interfere && iter == 2 && busy) begin
                start_valid = 1'b1; start_mode_chg = 1'b1;
                start_height = 8'd3; start_width = 10'd5;
            end else if (interfere && iter == 3) begin
                start_valid = 1'b0; start_mode_chg = 1'b0;
            end
            #1;
            if (snap_clear) begin snaps++; if (next_row > 0) snap_late = 1; end
            if (row_req) begin
                // R3: rows in increasing order from 0
                chk(int'(row_idx) == next_row, "R3 row order", int'(row_idx), next_row);
                if (snaps == 0) snap_late = 1;
                if (upd_valid) req_pend = 1;
                next_row++;
            end
            if (hold_prev) begin
                // R8: record held while not ready
                chk(upd_valid && int'(upd_y) == hy && int'(upd_h) == hh && int'(upd_w) == hw,
                    "R8 hold", int'(upd_y), hy);
            end
            hold_prev = upd_valid && !upd_ready;
            hy = int'(upd_y); hh = int'(upd_h); hw = int'(upd_w);
            if (upd_valid && upd_ready && got_n < 16) begin
                got_y[got_n] = int'(upd_y); got_h[got_n] = int'(upd_h);
                got_w[got_n] = int'(upd_w); got_x[got_n] = int'(upd_x); got_n++;
            end
            if (done) begin done_seen = 1; break; end
            @(negedge clk);
        end
        upd_ready = 1'b0;
        start_valid = 1'b0;
        // R9: done observed, with no record left pending
        chk(done_seen && !upd_valid, "R9 done", int'(done_seen), 1);
        @(negedge clk); #1;
        // R9: single-cycle pulse, busy falls
        chk(!done && !busy, "R9 pulse", int'(done) + int'(busy), 0);
        // R10: no stray record after an ignored start
        repeat (3) @(negedge clk);
        #1;
        chk(!upd_valid && !busy, "R10 no effect", int'(upd_valid), 0);
        // R7 R5 R6 R2: record count and contents
        chk(got_n == exp_n, mc ? "R2 count" : "R7 count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_y[i] == exp_y[i], mc ? "R2 y" : "R5 y", got_y[i], exp_y[i]);
            chk(got_h[i] == exp_h[i], mc ? "R2 h" : "R6 h", got_h[i], exp_h[i]);
            chk(got_w[i] == w, "R5 w", got_w[i], w);
            chk(got_x[i] == 0, "R5 x", got_x[i], 0);
        end
        if (mc) begin
            chk(snaps == 0 && next_row == 0, "R2 no scan", snaps + next_row, 0);
        end else begin
            // R3 R11: every row requested exactly once
            chk(next_row == h, (h == 0) ? "R11 rows" : "R3 rows", next_row, h);
            // R4: one snapshot strobe, before first row
            chk(snaps == 1 && !snap_late, "R4 snap", snaps, 1);
            // R8: no row requested while record pending
            chk(!req_pend, "R8 stall", int'(req_pend), 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: reset state
        chk(!busy && !snap_clear && !row_req && !upd_valid && !done, "R1 reset",
            int'(busy) + int'(snap_clear) + int'(row_req) + int'(upd_valid) + int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!busy && !upd_valid && !done, "R1 after reset", int'(busy), 0);
        for (int h = 1; h <= 6; h++)
            for (int p = 0; p < (1 << h); p++) begin
                pat = 16'(p);
                run_frame(h, 64 + h * 13, 1'b0, 1'b0);
            end
        pat = 16'h00FF; run_frame(8, 1000, 1'b0, 1'b0);
        pat = 16'h00A5; run_frame(8, 640, 1'b0, 1'b0);
        pat = 16'h0000; run_frame(8, 320, 1'b0, 1'b0);
        pat = 16'h0011; run_frame(5, 77, 1'b1, 1'b0);   // R2 mode change
        pat = 16'h0000; run_frame(8, 1023, 1'b1, 1'b0); // R2 mode change
        pat = 16'hFFFF; run_frame(0, 100, 1'b0, 1'b0);  // R11 zero height
        pat = 16'h0016; run_frame(6, 200, 1'b0, 1'b1);  // R10 start in mid-scan
        pat = 16'h0021; run_frame(6, 120, 1'b0, 1'b1);  // R10
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule